// File: doc/BRIEF.md
# ADC Calibration and Input-Mode Controller

This block is the digital control logic that sits beside a multi-channel successive-approximation converter. It keeps one input-mode bit per channel. A bit at 1 makes that channel differential: its negative input comes from the next channel up. The block also runs an automatic offset calibration, and it removes the stored offset from every conversion result before the result is handed on.

Two 7-bit offset factors are held: one for single-ended conversions and one for differential conversions. A calibration run drives the analog core through power-up, a 7-step binary search on the trim port, and power-down. It then writes its result into whichever factor the mode bit selected. Conversions are accepted only while the converter is enabled and ready. A channel that is serving as another channel's negative input is refused and flagged. Each accepted conversion uses the factor that matches the converted channel's mode.

Top module: `adc_cal_ctrl`

## Requirements
- R1: The mode-select register (address 1, bit i = channel i, 1 = differential) accepts writes only while the enable bit is 0; a write while enabled leaves the readback unchanged.
- R2: Mode bits of single-ended-only channels (parameter mask, default channels 6 and 7) and of the highest channel always read 0, whatever is written.
- R3: Control register (address 0): bit 0 enable, bit 1 calibrate (write-only strobe, reads back calibration busy), bit 2 calibration mode (0 single-ended, 1 differential). A calibration starts only from a write with bit 1 = 1 and bit 0 = 0 while enable is 0. Otherwise it is rejected: no busy flag, factors unchanged.
- R4: During calibration the power request is high from the start until the search ends. The run then drops the request and completes only after ready has returned low.
- R5: Calibration is a binary search over the 7-bit trim, MSB first, one bit per step. A bit is kept when the comparator reports 1 (trim not above the offset). The result is the largest trim the comparator accepts.
- R6: The result of a run is written only to the factor chosen by the mode bit. The other factor keeps its value. Factors read at address 2: bits 6:0 single-ended, bits 14:8 differential.
- R7: The calibration busy flag stays high for the whole run. The done flag pulses for exactly one cycle, in the first cycle busy is low, and the new factor is readable in that same cycle.
- R8: Both factors clear to 0 when the enable bit is written from 1 to 0.
- R9: A conversion request made while disabled or while calibrating is dropped: no request goes to the converter and no error is raised.
- R10: A request for channel k is refused when channel k-1 is differential. The error flag pulses one cycle later and no conversion is started.
- R11: An accepted conversion returns the raw 12-bit code minus the factor of the channel's mode, saturated at 0x000. Differential codes are offset binary, with 0x800 for zero difference.
- R12: The corrected result and a one-cycle done pulse appear in the cycle after the converter reports its raw result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data for reg_addr_i |
| conv_start_i | input | 1 | Conversion request |
| conv_ch_i | input | 3 | Requested channel |
| conv_done_o | output | 1 | Corrected result valid pulse |
| conv_data_o | output | 12 | Corrected result |
| conv_err_o | output | 1 | Refused-channel pulse |
| cal_busy_o | output | 1 | Calibration running |
| cal_done_o | output | 1 | Calibration complete pulse |
| pwr_req_o | output | 1 | Analog core power-up request |
| ana_rdy_i | input | 1 | Analog core powered and ready |
| trim_o | output | 7 | Trim value under test |
| cmp_i | input | 1 | Comparator: 1 when trim does not exceed the offset |
| sar_req_o | output | 1 | Conversion in progress on the converter |
| sar_ch_o | output | 3 | Channel being converted |
| sar_done_i | input | 1 | Converter raw result valid |
| sar_data_i | input | 12 | Converter raw result |

## Verification
The hardest case is showing that the two factors stay apart. Each one has to be written by its own calibration run and then both have to survive until a disable clears them. The bench reaches this by running a single-ended and a differential calibration against a stub whose comparator threshold differs per run. It then reads both factors after each run and converts on paired, unpaired and single-ended channels. A conversion request is also injected mid-calibration, and the extreme offsets 0 and 127 are calibrated after a clear.

// File: rtl/adc_cal_pkg.sv
package adc_cal_pkg;
  typedef enum logic [1:0] {CAL_IDLE, CAL_PWRUP, CAL_STEP, CAL_PWRDN} cal_state_e;
  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_MODE = 2'd1;
  localparam logic [1:0] ADDR_FACT = 2'd2;
endpackage

// File: rtl/adc_mode_regs.sv
module adc_mode_regs #(
  parameter int unsigned N_CH = 8,
  parameter logic [N_CH-1:0] SE_ONLY_MASK = 8'hC0
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_i,
  input  logic [N_CH-1:0] wdata_i,
  output logic [N_CH-1:0] dsel_o,
  output logic [N_CH-1:0] paired_o
);
  localparam logic [N_CH-1:0] TOP_BIT = {1'b1, {(N_CH-1){1'b0}}};
  localparam logic [N_CH-1:0] WR_MASK = ~SE_ONLY_MASK & ~TOP_BIT;

  logic [N_CH-1:0] dsel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   dsel_q <= '0;
    else if (wr_i) dsel_q <= wdata_i & WR_MASK;
  end

  assign dsel_o   = dsel_q;
  // channel k is the negative input of channel k-1
  assign paired_o = {dsel_q[N_CH-2:0], 1'b0};
endmodule

// File: rtl/adc_cal_seq.sv
module adc_cal_seq
  import adc_cal_pkg::*;
#(
  parameter int unsigned FW = 7
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          rdy_i,
  input  logic          cmp_i,
  output logic          busy_o,
  output logic          pwr_o,
  output logic          fin_o,
  output logic          done_o,
  output logic [FW-1:0] trim_o
);
  localparam int unsigned IW = (FW > 1) ? $clog2(FW) : 1;
  localparam logic [FW-1:0] ONE = {{(FW-1){1'b0}}, 1'b1};

  cal_state_e    state_q;
  logic [FW-1:0] trim_q;
  logic [IW-1:0] idx_q;
  logic          done_q;
  logic [FW-1:0] cur_bit;

  assign cur_bit = ONE << idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= CAL_IDLE;
      trim_q  <= '0;
      idx_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        CAL_IDLE:  if (start_i) state_q <= CAL_PWRUP;
        CAL_PWRUP: if (rdy_i) begin
          state_q <= CAL_STEP;
          trim_q  <= ONE << (FW-1);
          idx_q   <= IW'(FW-1);
        end
        CAL_STEP: begin
          trim_q <= (cmp_i ? trim_q : (trim_q & ~cur_bit)) |
                    ((idx_q != '0) ? (cur_bit >> 1) : '0);
          if (idx_q == '0) state_q <= CAL_PWRDN;
          else             idx_q   <= idx_q - 1'b1;
        end
        CAL_PWRDN: if (!rdy_i) begin
          state_q <= CAL_IDLE;
          done_q  <= 1'b1;
        end
        default: state_q <= CAL_IDLE;
      endcase
    end
  end

  assign busy_o = (state_q != CAL_IDLE);
  assign pwr_o  = (state_q == CAL_PWRUP) || (state_q == CAL_STEP);
  assign fin_o  = (state_q == CAL_PWRDN) && !rdy_i;
  assign done_o = done_q;
  assign trim_o = trim_q;
endmodule

// File: rtl/adc_conv_path.sv
module adc_conv_path #(
  parameter int unsigned N_CH = 8,
  parameter int unsigned FW   = 7,
  parameter int unsigned RW   = 12,
  parameter int unsigned CW   = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [CW-1:0]   ch_i,
  input  logic            allow_i,
  input  logic [N_CH-1:0] paired_i,
  input  logic [N_CH-1:0] dsel_i,
  input  logic [FW-1:0]   fac_se_i,
  input  logic [FW-1:0]   fac_diff_i,
  input  logic            sar_done_i,
  input  logic [RW-1:0]   sar_data_i,
  output logic            sar_req_o,
  output logic [CW-1:0]   sar_ch_o,
  output logic            done_o,
  output logic [RW-1:0]   data_o,
  output logic            err_o
);
  logic          busy_q, diff_q, done_q, err_q;
  logic [CW-1:0] ch_q;
  logic [RW-1:0] data_q;
  logic          take, refuse;
  logic [FW-1:0] fac;
  logic [RW:0]   sub;

  assign take   = start_i && allow_i && !busy_q && !paired_i[ch_i];
  assign refuse = start_i && allow_i && !busy_q &&  paired_i[ch_i];
  assign fac    = diff_q ? fac_diff_i : fac_se_i;
  assign sub    = {1'b0, sar_data_i} - {{(RW+1-FW){1'b0}}, fac};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      diff_q <= 1'b0;
      ch_q   <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      data_q <= '0;
    end else begin
      done_q <= 1'b0;
      err_q  <= refuse;
      if (take) begin
        busy_q <= 1'b1;
        ch_q   <= ch_i;
        diff_q <= dsel_i[ch_i];
      end else if (busy_q && sar_done_i) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
        data_q <= sub[RW] ? '0 : sub[RW-1:0];
      end
    end
  end

  assign sar_req_o = busy_q;
  assign sar_ch_o  = ch_q;
  assign done_o    = done_q;
  assign data_o    = data_q;
  assign err_o     = err_q;
endmodule

// File: rtl/adc_cal_ctrl.sv
module adc_cal_ctrl
  import adc_cal_pkg::*;
#(
  parameter int unsigned N_CH = 8,
  parameter logic [N_CH-1:0] SE_ONLY_MASK = 8'hC0,
  parameter int unsigned FW = 7,
  parameter int unsigned RW = 12,
  parameter int unsigned DW = 16,
  localparam int unsigned CW = $clog2(N_CH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_we_i,
  input  logic [1:0]    reg_addr_i,
  input  logic [DW-1:0] reg_wdata_i,
  output logic [DW-1:0] reg_rdata_o,
  input  logic          conv_start_i,
  input  logic [CW-1:0] conv_ch_i,
  output logic          conv_done_o,
  output logic [RW-1:0] conv_data_o,
  output logic          conv_err_o,
  output logic          cal_busy_o,
  output logic          cal_done_o,
  output logic          pwr_req_o,
  input  logic          ana_rdy_i,
  output logic [FW-1:0] trim_o,
  input  logic          cmp_i,
  output logic          sar_req_o,
  output logic [CW-1:0] sar_ch_o,
  input  logic          sar_done_i,
  input  logic [RW-1:0] sar_data_i
);
  logic            en_q, cal_diff_q;
  logic [FW-1:0]   fac_se, fac_diff;
  logic [N_CH-1:0] dsel, paired;
  logic            ctrl_wr, mode_wr, cal_start, cal_pwr, cal_fin, cal_busy;
  logic [FW-1:0]   cal_trim;

  assign ctrl_wr   = reg_we_i && (reg_addr_i == ADDR_CTRL) && !cal_busy;
  assign mode_wr   = reg_we_i && (reg_addr_i == ADDR_MODE) && !en_q;
  assign cal_start = ctrl_wr && reg_wdata_i[1] && !reg_wdata_i[0] && !en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q       <= 1'b0;
      cal_diff_q <= 1'b0;
      fac_se     <= '0;
      fac_diff   <= '0;
    end else begin
      if (ctrl_wr) begin
        en_q       <= reg_wdata_i[0];
        cal_diff_q <= reg_wdata_i[2];
      end
      if (ctrl_wr && en_q && !reg_wdata_i[0]) begin
        fac_se   <= '0;
        fac_diff <= '0;
      end else if (cal_fin) begin
        if (cal_diff_q) fac_diff <= cal_trim;
        else            fac_se   <= cal_trim;
      end
    end
  end

  adc_mode_regs #(.N_CH(N_CH), .SE_ONLY_MASK(SE_ONLY_MASK)) i_mode (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (mode_wr),
    .wdata_i  (reg_wdata_i[N_CH-1:0]),
    .dsel_o   (dsel),
    .paired_o (paired)
  );

  adc_cal_seq #(.FW(FW)) i_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (cal_start),
    .rdy_i   (ana_rdy_i),
    .cmp_i   (cmp_i),
    .busy_o  (cal_busy),
    .pwr_o   (cal_pwr),
    .fin_o   (cal_fin),
    .done_o  (cal_done_o),
    .trim_o  (cal_trim)
  );

  adc_conv_path #(.N_CH(N_CH), .FW(FW), .RW(RW), .CW(CW)) i_conv (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (conv_start_i),
    .ch_i       (conv_ch_i),
    .allow_i    (en_q && ana_rdy_i && !cal_busy),
    .paired_i   (paired),
    .dsel_i     (dsel),
    .fac_se_i   (fac_se),
    .fac_diff_i (fac_diff),
    .sar_done_i (sar_done_i),
    .sar_data_i (sar_data_i),
    .sar_req_o  (sar_req_o),
    .sar_ch_o   (sar_ch_o),
    .done_o     (conv_done_o),
    .data_o     (conv_data_o),
    .err_o      (conv_err_o)
  );

  assign cal_busy_o = cal_busy;
  assign pwr_req_o  = en_q | cal_pwr;
  assign trim_o     = cal_trim;

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      ADDR_CTRL: reg_rdata_o[2:0]      = {cal_diff_q, cal_busy, en_q};
      ADDR_MODE: reg_rdata_o[N_CH-1:0] = dsel;
      ADDR_FACT: begin
        reg_rdata_o[FW-1:0]   = fac_se;
        reg_rdata_o[FW+7:8]   = fac_diff;
      end
      default: reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/adc_cal_ctrl_chk.sv
module adc_cal_ctrl_chk #(
  parameter int unsigned N_CH = 8,
  parameter logic [N_CH-1:0] SE_ONLY_MASK = 8'hC0,
  parameter int unsigned FW = 7,
  parameter int unsigned DW = 16
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            en_q,
  input logic [N_CH-1:0] dsel,
  input logic [1:0]      reg_addr_i,
  input logic [DW-1:0]   reg_rdata_o,
  input logic            cal_busy_o,
  input logic            cal_done_o,
  input logic            pwr_req_o,
  input logic            sar_req_o,
  input logic            conv_err_o,
  input logic [FW-1:0]   fac_se,
  input logic [FW-1:0]   fac_diff
);
  localparam logic [N_CH-1:0] RO_MASK = SE_ONLY_MASK | {1'b1, {(N_CH-1){1'b0}}};

  // R1
  mode_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_q |=> $stable(dsel));
  // R2
  se_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i == 2'd1) |-> ((reg_rdata_o[N_CH-1:0] & RO_MASK) == '0));
  // R3
  cal_when_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_q |-> !cal_busy_o);
  // R4
  cal_pwr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cal_busy_o) |-> pwr_req_o);
  // R7
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cal_done_o |=> !cal_done_o);
  // R7
  done_at_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cal_busy_o) |-> cal_done_o);
  // R8
  fac_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(en_q) |-> (fac_se == '0 && fac_diff == '0));
  // R9
  conv_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cal_busy_o |-> !sar_req_o);
  // R10
  refuse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_err_o |-> !sar_req_o);
endmodule

bind adc_cal_ctrl adc_cal_ctrl_chk #(
  .N_CH(N_CH), .SE_ONLY_MASK(SE_ONLY_MASK), .FW(FW), .DW(DW)
) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .en_q        (en_q),
  .dsel        (dsel),
  .reg_addr_i  (reg_addr_i),
  .reg_rdata_o (reg_rdata_o),
  .cal_busy_o  (cal_busy_o),
  .cal_done_o  (cal_done_o),
  .pwr_req_o   (pwr_req_o),
  .sar_req_o   (sar_req_o),
  .conv_err_o  (conv_err_o),
  .fac_se      (fac_se),
  .fac_diff    (fac_diff)
);

// File: tb/test_adc_cal_ctrl.sv
`timescale 1ns/1ps
module test_adc_cal_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        conv_start = 1'b0;
  logic [2:0]  conv_ch = '0;
  logic        conv_done, conv_err, cal_busy, cal_done, pwr_req, sar_req;
  logic [11:0] conv_data;
  logic [6:0]  trim;
  logic [2:0]  sar_ch;
  logic        sar_done = 1'b0;
  logic [11:0] sar_data = '0;
  logic        rdy_d1, ana_rdy;
  int          stub_off = 0;
  int          n_chk = 0, n_fail = 0;
  int          m_se = 0, m_diff = 0;

  always #10 clk = ~clk;

  // analog stub: ready follows power request after two cycles
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin rdy_d1 <= 1'b0; ana_rdy <= 1'b0; end
    else begin rdy_d1 <= pwr_req; ana_rdy <= rdy_d1; end

  adc_cal_ctrl i_adc_cal_ctrl (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_we_i(reg_we), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .conv_start_i(conv_start), .conv_ch_i(conv_ch), .conv_done_o(conv_done),
    .conv_data_o(conv_data), .conv_err_o(conv_err),
    .cal_busy_o(cal_busy), .cal_done_o(cal_done), .pwr_req_o(pwr_req), .ana_rdy_i(ana_rdy),
    .trim_o(trim), .cmp_i(int'(trim) <= stub_off),
    .sar_req_o(sar_req), .sar_ch_o(sar_ch), .sar_done_i(sar_done), .sar_data_i(sar_data)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic reg_rd(input logic [1:0] a, output int v);
    reg_addr = a; #1; v = int'(reg_rdata);
  endtask

  task automatic check_facts(input string tag);
    int v;
    reg_rd(2'd2, v);
    chk({tag, " R6 se factor"}, v & 'h7F, m_se);
    chk({tag, " R6 diff factor"}, (v >> 8) & 'h7F, m_diff);
  endtask

  task automatic run_cal(input bit diff, input int off, input bit poke);
    int v;
    stub_off = off;
    reg_wr(2'd0, {13'b0, diff, 2'b10});
    chk("R7 busy at start", int'(cal_busy), 1);
    chk("R4 power at start", int'(pwr_req), 1);
    if (poke) begin
      conv_start = 1'b1; conv_ch = 3'd4;
      @(negedge clk); conv_start = 1'b0;
      chk("R9 no request during cal", int'(sar_req), 0);
      chk("R9 no error during cal", int'(conv_err), 0);
    end
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (!cal_busy) break;
    end
    chk("R7 done pulse", int'(cal_done), 1);
    chk("R4 power low at end", int'(pwr_req), 0);
    chk("R4 ready low at end", int'(ana_rdy), 0);
    if (diff) m_diff = off; else m_se = off;
    check_facts("R5 after cal");
    reg_rd(2'd0, v);
    chk("R7 busy low", v & 2, 0);
    @(negedge clk);
    chk("R7 done one cycle", int'(cal_done), 0);
  endtask

  task automatic conv(input int ch, input int raw, input bit diff_ch, input bit exp_err);
    int f, e;
    @(negedge clk); conv_start = 1'b1; conv_ch = 3'(ch);
    @(negedge clk); conv_start = 1'b0;
    if (exp_err) begin
      chk("R10 error pulse", int'(conv_err), 1);
      chk("R10 no request", int'(sar_req), 0);
      @(negedge clk);
      chk("R10 error one cycle", int'(conv_err), 0);
      return;
    end
    chk("R11 request", int'(sar_req), 1);
    chk("R11 channel", int'(sar_ch), ch);
    sar_done = 1'b1; sar_data = 12'(raw);
    @(negedge clk); sar_done = 1'b0;
    f = diff_ch ? m_diff : m_se;
    e = (raw > f) ? raw - f : 0;
    chk("R12 done", int'(conv_done), 1);
    chk("R11 data", int'(conv_data), e);
    @(negedge clk);
    chk("R12 done one cycle", int'(conv_done), 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    reg_rd(2'd0, v); chk("R3 reset ctrl", v, 0);
    reg_rd(2'd1, v); chk("R1 reset mode", v, 0);
    check_facts("R8 reset");
    chk("R4 reset power", int'(pwr_req), 0);

    run_cal(1'b0, 37, 1'b0);
    run_cal(1'b1, 90, 1'b0);

    reg_wr(2'd1, 16'h00FF);
    reg_rd(2'd1, v); chk("R2 masked mode bits", v, 'h3F);
    reg_wr(2'd1, 16'h0005);
    reg_rd(2'd1, v); chk("R1 write while disabled", v, 5);

    conv_start = 1'b1; conv_ch = 3'd4;
    @(negedge clk); conv_start = 1'b0;
    chk("R9 dropped while disabled", int'(sar_req), 0);
    chk("R9 no error while disabled", int'(conv_err), 0);

    reg_wr(2'd0, 16'h0001);
    repeat (3) @(negedge clk);
    reg_wr(2'd1, 16'h0000);
    reg_rd(2'd1, v); chk("R1 write while enabled ignored", v, 5);
    reg_wr(2'd0, 16'h0003);
    reg_rd(2'd0, v); chk("R3 cal rejected while enabled", v & 2, 0);
    check_facts("R3 rejected");

    conv(0, 'h800, 1'b1, 1'b0);
    conv(0, 'h000, 1'b1, 1'b0);
    conv(2, 'hFFF, 1'b1, 1'b0);
    conv(1, 'h123, 1'b0, 1'b1);
    conv(3, 'h123, 1'b0, 1'b1);
    conv(4, 'h100, 1'b0, 1'b0);
    conv(5, 10, 1'b0, 1'b0);
    conv(7, 'hFFF, 1'b0, 1'b0);
    conv(6, 37, 1'b0, 1'b0);

    reg_wr(2'd0, 16'h0000);
    m_se = 0; m_diff = 0;
    check_facts("R8 cleared on disable");

    run_cal(1'b0, 0, 1'b0);
    run_cal(1'b1, 127, 1'b1);

    reg_wr(2'd0, 16'h0001);
    repeat (3) @(negedge clk);
    conv(4, 'h050, 1'b0, 1'b0);
    conv(2, 'h07F, 1'b1, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule